// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the host-facing register file of a simple byte-oriented serial port. A 32-bit host bus with a word address reads and writes a small set of control, status and interrupt registers. On the line side it hands transmit bytes out over a valid/ready stream and takes received bytes in over another valid/ready stream. Bit timing, baud generation and queuing belong to neighbouring logic.

Writing the data-out register launches a byte and raises a transmit interrupt. An accepted received byte is latched into the status word, sets a data-available flag and raises a receive interrupt. The status word is visible at two addresses. One of them is a destructive read that clears data-available; the other only looks. Interrupts are cleared by writing ones to the acknowledge register, which never holds a value. A transmit that is still pending is signalled once more by the first acknowledge of bit 0. Incoming bytes are refused while a receive interrupt is unacknowledged, unless receive-control bit 0 allows overwriting.

Top module: `sio_regfile`

## Requirements
- R1: After reset, the status word reads 0x0140_0000 (bit 24 transmitter-ready = 1, bit 22 transmitter-idle = 1, bit 16 data-available = 0, bits 7:0 = 0). The raw, mask and masked interrupt registers read 0, irq_o is 0 and tx_valid is 0.
- R2: The register word addresses are: 0 transmit control, 1 transmit DMA enable, 2 receive control, 7 data out, 8 status with clear-on-read, 9 status peek, 11 interrupt mask, 12 acknowledge, 13 raw interrupt, 14 masked interrupt. Read data is valid combinationally in the cycle bus_sel=1 and bus_we=0, and is 0 otherwise.
- R3: A read of word 8 returns the current status word, and data-available is 0 from the next cycle on. A read of word 9 returns the same word and changes nothing.
- R4: A write to word 7 while no byte is held puts bits 7:0 on tx_data with tx_valid=1 from the next cycle. It stores the full value for readback, sets raw bit 0 and sets transmit-pending.
- R5: tx_valid and tx_data stay stable until a cycle with tx_ready=1, after which tx_valid is 0. A write to word 7 while tx_valid=1 changes nothing.
- R6: A byte accepted on the receive stream sets raw bit 3, replaces status bits 7:0 with the byte and sets data-available, all visible from the next cycle.
- R7: Writing word 12 clears every raw bit whose position is 1 in the written value. Word 12 always reads 0.
- R8: When transmit-pending is set, a write to word 12 with bit 0 = 1 clears pending and leaves raw bit 0 at 1. The next such write clears raw bit 0.
- R9: The masked register equals raw AND mask, and irq_o is 1 exactly when the masked register is non-zero.
- R10: rx_ready is 1 when receive-control bit 0 is 1 or when raw bit 3 is 0, and 0 otherwise.
- R11: Writes to words 8, 9, 13, 14 and to unmapped words change no state. Reads of unmapped words return 0.
- R12: A byte accepted in the same cycle as a read of word 8 leaves data-available at 1. A byte accepted in the same cycle as an acknowledge of bit 3 leaves raw bit 3 at 1.
- R13: Words 0, 1, 2 and 11 read back the full 32-bit value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_o | output | 1 | Level interrupt |
| tx_data | output | 8 | Transmit byte |
| tx_valid | output | 1 | Transmit byte held |
| tx_ready | input | 1 | Line side takes the transmit byte |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Block can take a received byte |

## Verification
Read data and rx_ready are combinational, so the bench samples them one nanosecond after driving an access, before the clock edge. Every state change (tx_valid, tx_data, the interrupt registers, data-available and irq_o) is due one edge after the access or byte that causes it. The bench therefore checks irq_o, tx_valid and tx_data on the falling edge after that clock, and checks register contents with a later read. A reference model in the bench applies each cycle's host effect first and the receive effect second, and each expected value comes from that model.

// File: rtl/sio_pkg.sv
package sio_pkg;

  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;

  // word indices of the register map
  localparam int IDX_TXCTL     = 0;
  localparam int IDX_TXDMA     = 1;
  localparam int IDX_RXCTL     = 2;
  localparam int IDX_DOUT      = 7;
  localparam int IDX_STAT_CLR  = 8;
  localparam int IDX_STAT_PEEK = 9;
  localparam int IDX_MASK      = 11;
  localparam int IDX_ACK       = 12;
  localparam int IDX_RAW       = 13;
  localparam int IDX_MASKED    = 14;

  // bit positions
  localparam int BIT_DAV    = 16;
  localparam int BIT_TXIDLE = 22;
  localparam int BIT_TXRDY  = 24;
  localparam int BIT_IRQ_TX = 0;
  localparam int BIT_IRQ_RX = 3;

  // plain read/write control words: transmit control, DMA enable, receive control
  localparam int NUM_CTL = 3;
  localparam int CTL_RX  = 2;

  typedef struct packed {
    logic [DATA_W-1:0] raw;
    logic              pending;
  } irq_state_t;

  function automatic int ctl_index(int k);
    case (k)
      0:       return IDX_TXCTL;
      1:       return IDX_TXDMA;
      default: return IDX_RXCTL;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] status_word(logic [BYTE_W-1:0] b, logic dav);
    logic [DATA_W-1:0] w;
    w = '0;
    w[BYTE_W-1:0] = b;
    w[BIT_DAV]    = dav;
    w[BIT_TXIDLE] = 1'b1;
    w[BIT_TXRDY]  = 1'b1;
    return w;
  endfunction

  // One cycle of interrupt state: host effect first, receive effect last.
  function automatic irq_state_t irq_step(irq_state_t cur, logic tx_set,
                                          logic ack_wr, logic [DATA_W-1:0] ack_val,
                                          logic rx_set);
    irq_state_t nxt;
    logic [DATA_W-1:0] ackv;
    nxt  = cur;
    ackv = ack_val;
    if (tx_set) begin
      nxt.raw[BIT_IRQ_TX] = 1'b1;
      nxt.pending         = 1'b1;
    end
    if (ack_wr) begin
      if (cur.pending && ackv[BIT_IRQ_TX]) begin
        nxt.raw[BIT_IRQ_TX] = 1'b1;
        nxt.pending         = 1'b0;
        ackv[BIT_IRQ_TX]    = 1'b0;
      end
      nxt.raw = nxt.raw & ~ackv;
    end
    if (rx_set) nxt.raw[BIT_IRQ_RX] = 1'b1;
    return nxt;
  endfunction

  function automatic logic [DATA_W-1:0] masked_of(logic [DATA_W-1:0] raw,
                                                  logic [DATA_W-1:0] mask);
    return raw & mask;
  endfunction

endpackage

// File: rtl/sio_addr_dec.sv
module sio_addr_dec
  import sio_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CTL-1:0] wr_ctl,
  output logic              wr_dout,
  output logic              wr_mask,
  output logic              wr_ack,
  output logic              rd_clr
);

  logic wr_any;
  logic rd_any;

  assign wr_any = sel && we;
  assign rd_any = sel && !we;

  for (genvar k = 0; k < NUM_CTL; k++) begin : g_ctl
    assign wr_ctl[k] = wr_any && (addr == ADDR_W'(ctl_index(k)));
  end

  assign wr_dout = wr_any && (addr == ADDR_W'(IDX_DOUT));
  assign wr_mask = wr_any && (addr == ADDR_W'(IDX_MASK));
  assign wr_ack  = wr_any && (addr == ADDR_W'(IDX_ACK));
  assign rd_clr  = rd_any && (addr == ADDR_W'(IDX_STAT_CLR));

endmodule

// File: rtl/sio_tx_slot.sv
module sio_tx_slot
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              tx_ready,
  output logic              tx_fire,
  output logic [DATA_W-1:0] dout_q,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid
);

  // a load is taken only when the slot is empty
  assign tx_fire = load && !tx_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_q   <= '0;
      tx_data  <= '0;
      tx_valid <= 1'b0;
    end else if (tx_fire) begin
      dout_q   <= load_val;
      tx_data  <= load_val[BYTE_W-1:0];
      tx_valid <= 1'b1;
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/sio_rx_status.sv
module sio_rx_status
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_fire,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rd_clr,
  output logic [BYTE_W-1:0] byte_q,
  output logic              dav_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_q <= '0;
      dav_q  <= 1'b0;
    end else if (rx_fire) begin
      byte_q <= rx_byte;
      dav_q  <= 1'b1;       // arrival wins over the clearing read
    end else if (rd_clr) begin
      dav_q  <= 1'b0;
    end
  end

endmodule

// File: rtl/sio_irq_unit.sv
module sio_irq_unit
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_set,
  input  logic              ack_wr,
  input  logic [DATA_W-1:0] ack_val,
  input  logic              rx_set,
  input  logic              mask_wr,
  input  logic [DATA_W-1:0] mask_val,
  output logic [DATA_W-1:0] raw_q,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] masked_q,
  output logic              pending_q,
  output logic              irq_o
);

  irq_state_t        cur;
  irq_state_t        nxt;
  logic [DATA_W-1:0] mask_nxt;
  logic [DATA_W-1:0] masked_nxt;

  assign cur        = '{raw: raw_q, pending: pending_q};
  assign nxt        = irq_step(cur, tx_set, ack_wr, ack_val, rx_set);
  assign mask_nxt   = mask_wr ? mask_val : mask_q;
  assign masked_nxt = masked_of(nxt.raw, mask_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q     <= '0;
      pending_q <= 1'b0;
      mask_q    <= '0;
      masked_q  <= '0;
      irq_o     <= 1'b0;
    end else begin
      raw_q     <= nxt.raw;
      pending_q <= nxt.pending;
      mask_q    <= mask_nxt;
      masked_q  <= masked_nxt;
      irq_o     <= |masked_nxt;
    end
  end

endmodule

// File: rtl/sio_regfile.sv
module sio_regfile
  import sio_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready
);

  // named internal events
  logic [NUM_CTL-1:0] wr_ctl;
  logic               wr_dout;
  logic               wr_mask;
  logic               wr_ack;
  logic               rd_clr;
  logic               tx_fire;
  logic               rx_fire;

  logic [NUM_CTL-1:0][DATA_W-1:0] ctl_q;
  logic [DATA_W-1:0]  dout_q;
  logic [DATA_W-1:0]  raw_q;
  logic [DATA_W-1:0]  mask_q;
  logic [DATA_W-1:0]  masked_q;
  logic               pending_q;
  logic [BYTE_W-1:0]  rx_byte_q;
  logic               dav_q;
  logic               rxctl0;
  logic [DATA_W-1:0]  rd_mux;

  sio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .sel     (bus_sel),
    .we      (bus_we),
    .addr    (bus_addr),
    .wr_ctl  (wr_ctl),
    .wr_dout (wr_dout),
    .wr_mask (wr_mask),
    .wr_ack  (wr_ack),
    .rd_clr  (rd_clr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      for (int k = 0; k < NUM_CTL; k++) begin
        if (wr_ctl[k]) ctl_q[k] <= bus_wdata;
      end
    end
  end

  assign rxctl0   = ctl_q[CTL_RX][0];
  assign rx_ready = rxctl0 || !raw_q[BIT_IRQ_RX];
  assign rx_fire  = rx_valid && rx_ready;

  sio_tx_slot u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_dout),
    .load_val (bus_wdata),
    .tx_ready (tx_ready),
    .tx_fire  (tx_fire),
    .dout_q   (dout_q),
    .tx_data  (tx_data),
    .tx_valid (tx_valid)
  );

  sio_rx_status u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_fire (rx_fire),
    .rx_byte (rx_data),
    .rd_clr  (rd_clr),
    .byte_q  (rx_byte_q),
    .dav_q   (dav_q)
  );

  sio_irq_unit u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_set    (tx_fire),
    .ack_wr    (wr_ack),
    .ack_val   (bus_wdata),
    .rx_set    (rx_fire),
    .mask_wr   (wr_mask),
    .mask_val  (bus_wdata),
    .raw_q     (raw_q),
    .mask_q    (mask_q),
    .masked_q  (masked_q),
    .pending_q (pending_q),
    .irq_o     (irq_o)
  );

  always_comb begin
    case (bus_addr)
      ADDR_W'(IDX_TXCTL):     rd_mux = ctl_q[0];
      ADDR_W'(IDX_TXDMA):     rd_mux = ctl_q[1];
      ADDR_W'(IDX_RXCTL):     rd_mux = ctl_q[CTL_RX];
      ADDR_W'(IDX_DOUT):      rd_mux = dout_q;
      ADDR_W'(IDX_STAT_CLR),
      ADDR_W'(IDX_STAT_PEEK): rd_mux = status_word(rx_byte_q, dav_q);
      ADDR_W'(IDX_MASK):      rd_mux = mask_q;
      ADDR_W'(IDX_RAW):       rd_mux = raw_q;
      ADDR_W'(IDX_MASKED):    rd_mux = masked_q;
      default:                rd_mux = '0;   // acknowledge and unmapped words
    endcase
  end

  assign bus_rdata = (bus_sel && !bus_we) ? rd_mux : '0;

endmodule

module sio_regfile_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              irq_o,
  input logic              tx_fire,
  input logic              rx_fire,
  input logic              pending_q,
  input logic              dav_q,
  input logic [DATA_W-1:0] raw_q,
  input logic [DATA_W-1:0] mask_q,
  input logic [DATA_W-1:0] masked_q
);

  a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  a_r4_tx_start: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fire |=> (tx_valid && raw_q[0] && pending_q));

  a_r6_rx_flags: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fire |=> (raw_q[3] && dav_q));

  a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
    masked_q == (raw_q & mask_q));

  a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|masked_q));

  a_r8_pending_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending_q) |-> $past(tx_fire));

endmodule

bind sio_regfile sio_regfile_chk #(.DATA_W(32)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .irq_o     (irq_o),
  .tx_fire   (tx_fire),
  .rx_fire   (rx_fire),
  .pending_q (pending_q),
  .dav_q     (dav_q),
  .raw_q     (raw_q),
  .mask_q    (mask_q),
  .masked_q  (masked_q)
);

// File: tb/sim_sio_regfile.sv
module sim_sio_regfile;

  localparam int AW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;

  always #2 clk = ~clk;   // 250 MHz

  sio_regfile #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference model
  logic [31:0] m_txctl = '0, m_txdma = '0, m_rxctl = '0, m_mask = '0;
  logic [31:0] m_dout = '0, m_raw = '0;
  logic        m_pending = 1'b0, m_dav = 1'b0, m_held = 1'b0;
  logic [7:0]  m_rxb = '0, m_txb = '0;
  logic [31:0] last_rd;

  function automatic logic [31:0] exp_status();
    return 32'h0140_0000 | (32'(m_dav) << 16) | 32'(m_rxb);
  endfunction

  function automatic logic [31:0] exp_read(logic [AW-1:0] a);
    case (a)
      4'd0:       return m_txctl;
      4'd1:       return m_txdma;
      4'd2:       return m_rxctl;
      4'd7:       return m_dout;
      4'd8, 4'd9: return exp_status();
      4'd11:      return m_mask;
      4'd13:      return m_raw;
      4'd14:      return m_raw & m_mask;
      default:    return 32'h0;
    endcase
  endfunction

  task automatic model_write(logic [AW-1:0] a, logic [31:0] d);
    logic [31:0] ackv;
    case (a)
      4'd0:  m_txctl = d;
      4'd1:  m_txdma = d;
      4'd2:  m_rxctl = d;
      4'd11: m_mask  = d;
      4'd7: if (!m_held) begin
        m_dout = d; m_txb = d[7:0]; m_held = 1'b1;
        m_raw[0] = 1'b1; m_pending = 1'b1;
      end
      4'd12: begin
        ackv = d;
        if (m_pending && ackv[0]) begin
          m_raw[0] = 1'b1; m_pending = 1'b0; ackv[0] = 1'b0;
        end
        m_raw = m_raw & ~ackv;
      end
      default: ;
    endcase
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one bus cycle plus optional receive byte and transmit acceptance
  task automatic op(bit sel, bit we, logic [AW-1:0] a, logic [31:0] d,
                    bit rxv, logic [7:0] rxb, bit txr, string tag);
    bit rdy;
    bit held0;
    @(negedge clk);
    bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = d;
    rx_valid = rxv; rx_data = rxb; tx_ready = txr;
    #1;
    rdy = m_rxctl[0] | ~m_raw[3];
    chk({tag, " R10 rx_ready"}, 32'(rx_ready), 32'(rdy));
    if (sel && !we) begin
      last_rd = bus_rdata;
      chk({tag, " R2 rdata"}, bus_rdata, exp_read(a));
    end
    held0 = m_held;
    if (sel && we) model_write(a, d);
    if (sel && !we && a == 4'd8) m_dav = 1'b0;
    if (rxv && rdy) begin
      m_raw[3] = 1'b1; m_rxb = rxb; m_dav = 1'b1;
    end
    if (held0 && txr) m_held = 1'b0;
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_we = 1'b0; rx_valid = 1'b0; tx_ready = 1'b0;
    @(negedge clk);
    chk({tag, " R9 irq"}, 32'(irq_o), 32'(|(m_raw & m_mask)));
    chk({tag, " R5 tx_valid"}, 32'(tx_valid), 32'(m_held));
    if (m_held) chk({tag, " R4 tx_data"}, 32'(tx_data), 32'(m_txb));
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d, string tag);
    op(1'b1, 1'b1, a, d, 1'b0, 8'h00, 1'b0, tag);
  endtask

  task automatic rd(logic [AW-1:0] a, logic [31:0] exp, string tag);
    op(1'b1, 1'b0, a, 32'h0, 1'b0, 8'h00, 1'b0, tag);
    chk({tag, " literal"}, last_rd, exp);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  function automatic logic [AW-1:0] pick_addr(int r);
    case (r % 12)
      0: return 4'd0;   1: return 4'd1;   2: return 4'd2;   3: return 4'd7;
      4: return 4'd8;   5: return 4'd9;   6: return 4'd11;  7: return 4'd12;
      8: return 4'd13;  9: return 4'd14;  10: return 4'd3;  default: return 4'd15;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs while in reset
    chk("R1 tx_valid in reset", 32'(tx_valid), 32'h0);
    chk("R1 irq in reset", 32'(irq_o), 32'h0);
    rst_n = 1'b1;

    // R1 reset values
    rd(4'd9,  32'h0140_0000, "R1 status");
    rd(4'd13, 32'h0, "R1 raw");
    rd(4'd14, 32'h0, "R1 masked");
    rd(4'd11, 32'h0, "R1 mask");

    // R13 control words read back
    wr(4'd0, 32'hDEAD_BEEF, "R13 txctl");
    rd(4'd0, 32'hDEAD_BEEF, "R13 txctl");
    wr(4'd1, 32'h1234_5678, "R13 txdma");
    rd(4'd1, 32'h1234_5678, "R13 txdma");

    // R4 transmit start
    wr(4'd7, 32'hA5A5_1234, "R4 dout");
    chk("R4 tx_valid", 32'(tx_valid), 32'h1);
    chk("R4 tx_data", 32'(tx_data), 32'h34);
    rd(4'd13, 32'h1, "R4 raw0");
    rd(4'd7, 32'hA5A5_1234, "R4 dout readback");

    // R5 write while held is dropped, then drain
    wr(4'd7, 32'h0000_0055, "R5 dropped dout");
    chk("R5 tx_data held", 32'(tx_data), 32'h34);
    rd(4'd7, 32'hA5A5_1234, "R5 dout unchanged");
    op(1'b0, 1'b0, 4'd0, 32'h0, 1'b0, 8'h00, 1'b1, "R5 drain");
    chk("R5 tx_valid after ready", 32'(tx_valid), 32'h0);

    // R9 mask and irq
    wr(4'd11, 32'h0000_0009, "R9 mask");
    chk("R9 irq on", 32'(irq_o), 32'h1);
    rd(4'd14, 32'h1, "R9 masked");

    // R8 pending resignal, then R7 clear
    wr(4'd12, 32'h1, "R8 first ack");
    rd(4'd13, 32'h1, "R8 raw0 kept");
    chk("R8 irq still on", 32'(irq_o), 32'h1);
    wr(4'd12, 32'h1, "R8 second ack");
    rd(4'd13, 32'h0, "R8 raw0 cleared");
    chk("R7 irq off", 32'(irq_o), 32'h0);
    rd(4'd12, 32'h0, "R7 ack reads zero");

    // R6 receive, R10 flow control, R3 clearing read
    op(1'b0, 1'b0, 4'd0, 32'h0, 1'b1, 8'h5A, 1'b0, "R6 rx byte");
    rd(4'd9, 32'h0141_005A, "R6 status");
    chk("R6 irq rx", 32'(irq_o), 32'h1);
    chk("R10 rx_ready low", 32'(rx_ready), 32'h0);
    op(1'b0, 1'b0, 4'd0, 32'h0, 1'b1, 8'h77, 1'b0, "R10 refused byte");
    rd(4'd9, 32'h0141_005A, "R10 byte kept");
    rd(4'd8, 32'h0141_005A, "R3 clearing read");
    rd(4'd9, 32'h0140_005A, "R3 dav cleared");
    rd(4'd9, 32'h0140_005A, "R3 peek no change");
    wr(4'd12, 32'h8, "R7 ack rx");
    rd(4'd13, 32'h0, "R7 raw3 cleared");

    // R12 same-cycle priorities
    op(1'b1, 1'b0, 4'd8, 32'h0, 1'b1, 8'h11, 1'b0, "R12 read with rx");
    chk("R12 old word returned", last_rd, 32'h0140_005A);
    rd(4'd9, 32'h0141_0011, "R12 dav kept");
    wr(4'd2, 32'h1, "R10 overwrite enable");
    chk("R10 rx_ready high", 32'(rx_ready), 32'h1);
    op(1'b1, 1'b1, 4'd12, 32'h8, 1'b1, 8'h22, 1'b0, "R12 ack with rx");
    rd(4'd13, 32'h8, "R12 raw3 kept");

    // R11 ignored writes and unmapped reads
    wr(4'd13, 32'hFFFF_FFFF, "R11 raw write");
    wr(4'd14, 32'hFFFF_FFFF, "R11 masked write");
    wr(4'd9,  32'h0000_00FF, "R11 peek write");
    wr(4'd8,  32'h0000_00FF, "R11 status write");
    wr(4'd15, 32'hFFFF_FFFF, "R11 unmapped write");
    rd(4'd13, 32'h8, "R11 raw unchanged");
    rd(4'd9,  32'h0141_0022, "R11 status unchanged");
    rd(4'd15, 32'h0, "R11 unmapped read");
    rd(4'd3,  32'h0, "R11 unmapped read");

    // constrained random mix, all checked against the model
    for (int i = 0; i < 600; i++) begin
      int kind;
      logic [AW-1:0] a;
      logic [31:0] d;
      bit rxv;
      bit txr;
      kind = $urandom_range(0, 9);
      a    = pick_addr(int'($urandom_range(0, 11)));
      d    = $urandom();
      if (a == 4'd12 && $urandom_range(0, 1) == 1) d = d & 32'hF;
      rxv  = ($urandom_range(0, 3) == 0);
      txr  = ($urandom_range(0, 4) == 0);
      if (kind < 4)      op(1'b1, 1'b1, a, d, rxv, 8'($urandom()), txr, "R2 R4 R7 R8 random write");
      else if (kind < 7) op(1'b1, 1'b0, a, 32'h0, rxv, 8'($urandom()), txr, "R3 R11 random read");
      else if (kind < 9) op(1'b0, 1'b0, 4'd0, 32'h0, 1'b1, 8'($urandom()), txr, "R6 random rx");
      else               op(1'b0, 1'b0, 4'd0, 32'h0, 1'b0, 8'h00, 1'b1, "R5 random drain");
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule